// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block sends bytes on a serial line as 8N1 frames. A one-byte holding register sits in front of the shift register, so software can queue the next byte while the current one is still going out. Two status conditions are kept apart. The first, "holding empty", says that a new byte can be written. It is set again as soon as the queued byte moves into the shift register. The second, "line drained", says that the last frame, stop bit included, has fully left the line and nothing is waiting behind it. A half-duplex driver can poll the drained flag, or take its interrupt, to know the moment it may turn the line driver off.

The drained flag is sticky. It is cleared in one of two ways: an acknowledge pulse on the interrupt side, or a write-one-to-clear on the control port. The bit period is a fixed parameter `DIV`, given in clock cycles.

The transmit state machine has four named states:
- `TX_IDLE`: the line is high.
- `TX_START`: the line is low.
- `TX_DATA`: the 8 data bits go out, LSB first.
- `TX_STOP`: the line is high.

Its transitions are:
- LOAD (IDLE→START): taken when the holding register is full.
- BEGIN (START→DATA): taken after one bit period.
- LAST (DATA→STOP): taken after the eighth bit.
- CHAIN (STOP→START): taken when a byte is waiting at the end of the stop bit.
- DRAIN (STOP→IDLE): taken when nothing is waiting, and it sets the drained flag.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `status` is 2'b01 (bit 0 = holding empty, bit 1 = line drained), `tx_line` is 1, `irq_empty` is 1 and `irq_done` is 0.
- R2: A frame is a low start bit, then 8 data bits LSB first, then a high stop bit. Each bit lasts `DIV` clock cycles.
- R3: A write with `wr_en` while `status[0]` is 1 is accepted, and `status[0]` reads 0 in the cycle after the write.
- R4: When the transmitter is idle, the byte moves into the shift register one cycle after the write, and `status[0]` returns to 1 in the cycle after that.
- R5: A write while `status[0]` is 0 is ignored: that byte is never sent.
- R6: A byte that is held while a frame is in progress starts right after that frame's stop bit, with no idle gap. The two start bits are 10·`DIV` cycles apart.
- R7: `status[1]` is set only at the end of a stop bit when no byte is waiting. It stays 0 between chained frames, and it reads 1 exactly 1+10·`DIV` cycles after an accepted write to an idle transmitter.
- R8: A one-cycle pulse on `irq_done_ack` clears `status[1]` in the next cycle.
- R9: A control write (`ctl_wr`) with `ctl_done_w1`=1 clears `status[1]`. A control write with `ctl_done_w1`=0 leaves it unchanged.
- R10: `irq_empty` follows `status[0]`, and `irq_done` follows `status[1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to transmit |
| ctl_wr | input | 1 | Control write strobe |
| ctl_done_w1 | input | 1 | Value written to the drained flag position (1 clears it) |
| irq_done_ack | input | 1 | Acknowledge pulse for the drained interrupt |
| status | output | 2 | {line drained, holding empty} |
| irq_empty | output | 1 | Holding-empty interrupt |
| irq_done | output | 1 | Line-drained interrupt |
| tx_line | output | 1 | Serial output, idles high |

## Verification
A shift register that loses its place shows up on `tx_line` within one frame. The decoded byte differs from the scoreboard entry, or the start or stop level is wrong at mid-bit.

A holding register that is overwritten while full, or never released, shows up within one frame in two ways. The frame count is wrong, or `status[0]` stays stuck for longer than the single cycle R4 allows.

A drained flag that sets early, in the gap between chained frames, is caught before the last frame ends. A flag that ignores a clear is caught one cycle after the acknowledge or the control write.

// File: rtl/uart_txd_pkg.sv
package uart_txd_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;

    localparam int STAT_EMPTY_BIT = 0;
    localparam int STAT_DONE_BIT  = 1;
    localparam int DATA_BITS      = 8;
endpackage

// File: rtl/uart_txd_baud.sv
module uart_txd_baud #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!run || restart)  cnt_q <= '0;
        else if (cnt_q == LAST)    cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/uart_txd_hold.sv
module uart_txd_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end
endmodule

// File: rtl/uart_txd_shift.sv
module uart_txd_shift
    import uart_txd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_full,
    input  logic [W-1:0] hold_data,
    input  logic         tick,
    output logic         take,
    output logic         done_set,
    output logic         run,
    output logic         line,
    output tx_state_e    state
);
    localparam int BW = (W > 2) ? $clog2(W) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

    tx_state_e      state_q, state_d;
    logic [W-1:0]   shreg_q;
    logic [BW-1:0]  bit_q;

    always_comb begin
        state_d  = state_q;
        take     = 1'b0;
        done_set = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (hold_full) begin
                    take    = 1'b1;
                    state_d = TX_START;
                end
            end
            TX_START: begin
                if (tick) state_d = TX_DATA;
            end
            TX_DATA: begin
                if (tick && bit_q == LAST_BIT) state_d = TX_STOP;
            end
            TX_STOP: begin
                if (tick) begin
                    if (hold_full) begin
                        take    = 1'b1;
                        state_d = TX_START;
                    end else begin
                        done_set = 1'b1;
                        state_d  = TX_IDLE;
                    end
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bit_q   <= '0;
        end else if (take) begin
            shreg_q <= hold_data;
            bit_q   <= '0;
        end else if (state_q == TX_DATA && tick) begin
            shreg_q <= shreg_q >> 1;
            bit_q   <= bit_q + 1'b1;
        end
    end

    always_comb begin
        unique case (state_q)
            TX_START: line = 1'b0;
            TX_DATA:  line = shreg_q[0];
            default:  line = 1'b1;
        endcase
        run   = (state_q != TX_IDLE);
        state = state_q;
    end
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
    import uart_txd_pkg::*;
#(
    parameter int DIV = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       ctl_wr,
    input  logic       ctl_done_w1,
    input  logic       irq_done_ack,
    output logic [1:0] status,
    output logic       irq_empty,
    output logic       irq_done,
    output logic       tx_line
);
    logic                 hold_full_w;
    logic [DATA_BITS-1:0] hold_data_w;
    logic                 take_w;
    logic                 done_set_w;
    logic                 run_w;
    logic                 tick_w;
    tx_state_e            state_w;
    logic                 done_q;

    uart_txd_hold #(.W(DATA_BITS)) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take_w),
        .full    (hold_full_w),
        .data    (hold_data_w)
    );

    uart_txd_baud #(.DIV(DIV)) baud_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_w),
        .restart (take_w),
        .tick    (tick_w)
    );

    uart_txd_shift #(.W(DATA_BITS)) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_full (hold_full_w),
        .hold_data (hold_data_w),
        .tick      (tick_w),
        .take      (take_w),
        .done_set  (done_set_w),
        .run       (run_w),
        .line      (tx_line),
        .state     (state_w)
    );

    // A new completion event takes priority over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  done_q <= 1'b0;
        else if (done_set_w)                         done_q <= 1'b1;
        else if (irq_done_ack || (ctl_wr && ctl_done_w1)) done_q <= 1'b0;
    end

    always_comb begin
        status                 = '0;
        status[STAT_EMPTY_BIT] = !hold_full_w;
        status[STAT_DONE_BIT]  = done_q;
        irq_empty              = !hold_full_w;
        irq_done               = done_q;
    end
endmodule

// File: rtl/uart_txd_chk.sv
module uart_txd_chk
    import uart_txd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       irq_done_ack,
    input logic [1:0] status,
    input logic       tx_line,
    input logic       hold_full,
    input logic [7:0] hold_data,
    input logic       take,
    input logic       done_set,
    input tx_state_e  state
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE) |-> tx_line);

    assert_full_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && !take && wr_en) |=> (hold_full && $stable(hold_data)));

    assert_empty_after_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> status[STAT_EMPTY_BIT]);

    assert_done_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[STAT_DONE_BIT]) |-> ($past(state) == TX_STOP && state == TX_IDLE));

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_done_ack && !done_set) |=> !status[STAT_DONE_BIT]);
endmodule

bind uart_tx_dbuf uart_txd_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .irq_done_ack (irq_done_ack),
    .status       (status),
    .tx_line      (tx_line),
    .hold_full    (hold_full_w),
    .hold_data    (hold_data_w),
    .take         (take_w),
    .done_set     (done_set_w),
    .state        (state_w)
);

// File: tb/uart_tx_dbuf_tb_top.sv
`timescale 1ns/1ps
module uart_tx_dbuf_tb_top;
    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ctl_wr = 1'b0;
    logic       ctl_done_w1 = 1'b0;
    logic       irq_done_ack = 1'b0;
    logic [1:0] status;
    logic       irq_empty, irq_done, tx_line;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nframes = 0;
    int starts[$];
    logic [7:0] exp_q[$];
    bit finished = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_tx_dbuf #(.DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ctl_wr(ctl_wr), .ctl_done_w1(ctl_done_w1), .irq_done_ack(irq_done_ack),
        .status(status), .irq_empty(irq_empty), .irq_done(irq_done), .tx_line(tx_line)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Driver: an accepted write pushes the expected byte.
    task automatic drive_byte(input logic [7:0] b, input bit accept);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        if (accept) exp_q.push_back(b);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_done(output int when);
        when = -1;
        for (int i = 0; i < 40 * DIV; i++) begin
            @(negedge clk);
            if (status[1]) begin when = cyc; break; end
        end
    endtask

    // Monitor: decodes frames at mid-bit, compares against the scoreboard.
    initial begin
        forever begin
            logic [7:0] got;
            @(negedge clk);
            if (rst_n && !tx_line) begin
                starts.push_back(cyc);
                repeat (DIV/2 - 1) @(negedge clk);
                chk(tx_line == 1'b0, "R2 start bit", tx_line, 0);
                for (int b = 0; b < 8; b++) begin
                    repeat (DIV) @(negedge clk);
                    got[b] = tx_line;
                end
                repeat (DIV) @(negedge clk);
                chk(tx_line == 1'b1, "R2 stop bit", tx_line, 1);
                nframes++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected frame", got, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(got == e, "R2 data byte", got, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int c0, t_done;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state and R10 mirroring
        chk(status == 2'b01, "R1 status", status, 1);
        chk(tx_line == 1'b1, "R1 line", tx_line, 1);
        chk(irq_empty == 1'b1 && irq_done == 1'b0, "R1 R10 irq", {irq_empty, irq_done}, 2'b10);

        // Write 0xA5, then a write while holding is full (ignored)
        wr_en = 1'b1; wr_data = 8'hA5; exp_q.push_back(8'hA5);
        @(negedge clk);
        c0 = cyc;
        chk(status[0] == 1'b0, "R3 empty cleared", status[0], 0);
        chk(irq_empty == 1'b0, "R10 irq_empty", irq_empty, 0);
        wr_data = 8'h5A;          // ignored (R5)
        @(negedge clk);
        wr_en = 1'b0;
        chk(status[0] == 1'b1, "R4 empty set after move", status[0], 1);
        chk(status[1] == 1'b0, "R7 not done mid-frame", status[1], 0);
        wait_done(t_done);
        chk(t_done == c0 + 1 + 10 * DIV, "R7 done timing", t_done, c0 + 1 + 10 * DIV);
        chk(irq_done == 1'b1, "R10 irq_done", irq_done, 1);
        repeat (3 * DIV) begin
            @(negedge clk);
            if (!tx_line) chk(1'b0, "R5 extra frame", 0, 1);
        end
        chk(nframes == 1, "R5 frame count", nframes, 1);

        // R8 acknowledge
        @(negedge clk); irq_done_ack = 1'b1;
        @(negedge clk); irq_done_ack = 1'b0;
        chk(status[1] == 1'b0, "R8 ack clears", status[1], 0);

        // Chained frames: 0x00 then held 0xFF; a third write while full is ignored
        drive_byte(8'h00, 1'b1);
        repeat (2) @(negedge clk);
        drive_byte(8'hFF, 1'b1);
        chk(status[0] == 1'b0, "R3 held byte", status[0], 0);
        drive_byte(8'h77, 1'b0);
        for (int i = 0; i < 40 * DIV; i++) begin
            @(negedge clk);
            if (status[1]) break;
        end
        chk(nframes == 3, "R7 done only after last frame", nframes, 3);
        chk(starts.size() == 3 && (starts[2] - starts[1]) == 10 * DIV,
            "R6 no gap", starts[2] - starts[1], 10 * DIV);

        // R9 write-one-to-clear
        @(negedge clk); ctl_wr = 1'b1; ctl_done_w1 = 1'b0;
        @(negedge clk); ctl_wr = 1'b0;
        chk(status[1] == 1'b1, "R9 write zero keeps", status[1], 1);
        ctl_wr = 1'b1; ctl_done_w1 = 1'b1;
        @(negedge clk); ctl_wr = 1'b0; ctl_done_w1 = 1'b0;
        chk(status[1] == 1'b0, "R9 write one clears", status[1], 0);
        chk(irq_done == 1'b0, "R10 irq_done cleared", irq_done, 0);

        // One more pattern, polled
        drive_byte(8'h3C, 1'b1);
        wait_done(t_done);
        chk(t_done > 0, "R7 polled done", t_done, 1);
        repeat (2) @(negedge clk);
        chk(nframes == 4 && exp_q.size() == 0, "R2 scoreboard drained", nframes, 4);
        finish_run();
    end
endmodule